// File: doc/BRIEF.md
# Bidirectional Port Controller with Change and Edge Interrupts

This block controls an 8-bit general-purpose port. Each pin has its own bit in an output latch and a bit in a direction register. A direction bit of 1 sets the pin as an input, with its driver off. A direction bit of 0 drives the latched value onto the pin. One active-low option input turns on weak pull-ups for every pin that is set as an input. Reading the port returns the pin levels after they pass through a synchronizer. Writing the port loads the output latch.

The block raises two interrupt flags:

- **Change flag.** The upper four pins are watched for a change. Each one that is set as an input is compared with a snapshot of the pins. The snapshot is taken on every port read or write. Any difference sets the change flag and asserts a wake request. Only a port access ends the difference, so software must read or write the port before clearing the flag.
- **Edge flag.** Pin 0 also works as an external interrupt input. Its active edge, rising or falling, is chosen by an option input, and a detected edge sets the edge flag.

Both flags are cleared by software strobes.

Top module: `bidir_port_ctrl`

## Requirements
- R1: After a synchronous reset, the direction readback is all ones. The pin output enables, latch outputs, pull-up enables, change flag, edge flag, wake request and read data are all zero.
- R2: A direction write loads `dir_wdata` into the direction register. From the next cycle, `dir_q` shows the written value and `pin_oe` shows its bitwise inverse (a 0 direction bit enables the driver).
- R3: A read strobe captures the synchronized pin levels into `rd_data`, which is visible the cycle after the strobe. A change on a pin reaches the synchronized levels two clocks after it arrives.
- R4: A write strobe loads `wr_data` into the output latch, seen on `pin_out` the next cycle, whatever the direction bits are.
- R5: `pin_pu[i]` is 1 exactly when `pu_off_n` is 0 and pin i is set as an input. A pin set as an output never has its pull-up enabled.
- R6: A difference between a synchronized input pin among bits 7..4 and the snapshot sets `chg_flag` and asserts `wake_req`. Changes on bits 3..0 never do either.
- R7: An upper pin whose direction bit is 0 (output) is left out of the change comparison.
- R8: While a difference persists, a `chg_clr` strobe does not leave the flag clear. A clear after the difference has ended leaves the flag at 0.
- R9: A port read or a port write refreshes the snapshot from the synchronized pins. This ends the difference, and `wake_req` is 0 the cycle after the access.
- R10: With `edge_rise` = 1 a rising edge on synchronized pin 0 sets `edge_flag`. With `edge_rise` = 0 a falling edge sets it. The edge of the other polarity has no effect.
- R11: If an edge event and an `edge_clr` strobe fall in the same cycle, `edge_flag` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 8 | Pin levels seen from outside |
| rd_stb | input | 1 | Port read strobe |
| wr_stb | input | 1 | Port write strobe |
| wr_data | input | 8 | Data for the output latch |
| dir_wr | input | 1 | Direction register write strobe |
| dir_wdata | input | 8 | Direction data (1 = input) |
| pu_off_n | input | 1 | Active-low global pull-up enable |
| edge_rise | input | 1 | Pin 0 edge select: 1 rising, 0 falling |
| chg_clr | input | 1 | Software clear of the change flag |
| edge_clr | input | 1 | Software clear of the edge flag |
| pin_out | output | 8 | Output latch driven to the pins |
| pin_oe | output | 8 | Per-pin driver enable |
| pin_pu | output | 8 | Per-pin weak pull-up enable |
| dir_q | output | 8 | Direction register readback |
| rd_data | output | 8 | Captured pin levels of the last read |
| chg_flag | output | 1 | Change interrupt flag |
| edge_flag | output | 1 | Pin 0 edge interrupt flag |
| wake_req | output | 1 | Wake request while a change difference exists |

## Verification
A software clear can land in the same cycle as the set condition of its flag. This can happen for the change flag, while a difference persists, and for the edge flag, when a synchronized edge arrives.

The bench provokes the change-flag case by strobing `chg_clr` before any port access, and judges that the flag reads 1 afterwards. It provokes the edge-flag case by counting clocks from a pin 0 transition and holding `edge_clr` across the exact edge at which the event is captured, and judges that the flag reads 1 afterwards.

Both checks are then followed by an access or a plain clear, to show that the flag does go to 0 once no set condition remains.

// File: rtl/portctl_pkg.sv
package portctl_pkg;
  // Mask with ones from bit lo up to bit width-1.
  function automatic logic [63:0] span_mask(int width, int lo);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      m[i] = (i >= lo) && (i < width);
    end
    return m;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/port_regs.sv
module port_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         dir_wr,
  input  logic [W-1:0] dir_wdata,
  input  logic         pu_off_n,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] dir_next;

  assign dir_next = dir_wr ? dir_wdata : dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= '0;
      dir_q   <= '1;
      pin_oe  <= '0;
      pin_pu  <= '0;
      rd_data <= '0;
    end else begin
      if (wr_stb) pin_out <= wr_data;
      if (rd_stb) rd_data <= pin_s;
      dir_q  <= dir_next;
      pin_oe <= ~dir_next;
      pin_pu <= dir_next & {W{~pu_off_n}};
    end
  end

  // R2
  dir_to_oe_chk: assert property (@(posedge clk) disable iff (rst)
    dir_wr |=> (pin_oe == ~$past(dir_wdata)));
  // R3
  read_capture_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (rd_data == $past(pin_s)));
  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (pin_out == $past(wr_data)));
  // R5
  pu_on_output_chk: assert property (@(posedge clk) disable iff (rst)
    (pin_pu & pin_oe) == '0);
endmodule

// File: rtl/change_det.sv
module change_det #(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] dir_q,
  input  logic         access,
  input  logic         clr,
  output logic         chg_flag,
  output logic         wake_req
);
  import portctl_pkg::*;

  localparam logic [W-1:0] WATCH = W'(span_mask(W, CHG_LO));

  logic [W-1:0] snap;
  logic         diff_any;
  logic         mis;

  assign diff_any = |((pin_s ^ snap) & dir_q & WATCH);
  // An access compares the pins against themselves: no difference.
  assign mis      = diff_any & ~access;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap     <= '0;
      chg_flag <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      if (access) snap <= pin_s;
      chg_flag <= mis | (chg_flag & ~clr);
      wake_req <= mis;
    end
  end

  // R8
  mismatch_sets_chk: assert property (@(posedge clk) disable iff (rst)
    mis |=> chg_flag);
  // R9
  access_ends_chk: assert property (@(posedge clk) disable iff (rst)
    access |=> !wake_req);
  // R6
  wake_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wake_req |-> chg_flag);
endmodule

// File: rtl/edge_det.sv
module edge_det (
  input  logic clk,
  input  logic rst,
  input  logic pin0_s,
  input  logic edge_rise,
  input  logic clr,
  output logic edge_flag
);
  logic prev;
  logic ev;

  assign ev = edge_rise ? (pin0_s & ~prev) : (~pin0_s & prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev      <= 1'b0;
      edge_flag <= 1'b0;
    end else begin
      prev      <= pin0_s;
      edge_flag <= ev | (edge_flag & ~clr);
    end
  end

  // R11
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ev |=> edge_flag);
  // R10
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    (!ev && clr) |=> !edge_flag);
endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl #(
  parameter int W           = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic         rd_stb,
  input  logic         wr_stb,
  input  logic [W-1:0] wr_data,
  input  logic         dir_wr,
  input  logic [W-1:0] dir_wdata,
  input  logic         pu_off_n,
  input  logic         edge_rise,
  input  logic         chg_clr,
  input  logic         edge_clr,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_data,
  output logic         chg_flag,
  output logic         edge_flag,
  output logic         wake_req
);
  logic [W-1:0] pin_s;
  logic         access;

  assign access = rd_stb | wr_stb;

  pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  port_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .pin_s     (pin_s),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .dir_wr    (dir_wr),
    .dir_wdata (dir_wdata),
    .pu_off_n  (pu_off_n),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_pu    (pin_pu),
    .dir_q     (dir_q),
    .rd_data   (rd_data)
  );

  change_det #(.W(W), .CHG_LO(CHG_LO)) u_chg (
    .clk      (clk),
    .rst      (rst),
    .pin_s    (pin_s),
    .dir_q    (dir_q),
    .access   (access),
    .clr      (chg_clr),
    .chg_flag (chg_flag),
    .wake_req (wake_req)
  );

  edge_det u_edge (
    .clk       (clk),
    .rst       (rst),
    .pin0_s    (pin_s[0]),
    .edge_rise (edge_rise),
    .clr       (edge_clr),
    .edge_flag (edge_flag)
  );
endmodule

// File: tb/test_bidir_port_ctrl.sv
`timescale 1ns/1ps
module test_bidir_port_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] pin_in;
  logic       rd_stb, wr_stb, dir_wr, pu_off_n, edge_rise, chg_clr, edge_clr;
  logic [7:0] wr_data, dir_wdata;
  logic [7:0] pin_out, pin_oe, pin_pu, dir_q, rd_data;
  logic       chg_flag, edge_flag, wake_req;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  bidir_port_ctrl i_bidir_port_ctrl (
    .clk(clk), .rst(rst), .pin_in(pin_in), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wr_data(wr_data), .dir_wr(dir_wr), .dir_wdata(dir_wdata),
    .pu_off_n(pu_off_n), .edge_rise(edge_rise), .chg_clr(chg_clr),
    .edge_clr(edge_clr), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .dir_q(dir_q), .rd_data(rd_data), .chg_flag(chg_flag),
    .edge_flag(edge_flag), .wake_req(wake_req)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic do_write(logic [7:0] v);
    wr_data = v; wr_stb = 1'b1; @(negedge clk); wr_stb = 1'b0;
  endtask

  task automatic set_dir(logic [7:0] v);
    dir_wdata = v; dir_wr = 1'b1; @(negedge clk); dir_wr = 1'b0;
  endtask

  task automatic clr_chg();
    chg_clr = 1'b1; @(negedge clk); chg_clr = 1'b0;
  endtask

  task automatic clr_edge();
    edge_clr = 1'b1; @(negedge clk); edge_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dir_q", dir_q, 8'hFF);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 pin_pu", pin_pu, 8'h00);
    chk("R1 flags", {5'b0, chg_flag, edge_flag, wake_req}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
  endtask

  task automatic t_dir_latch();
    do_write(8'hA5);
    chk("R4 latch with all inputs", pin_out, 8'hA5);
    set_dir(8'h0F);
    chk("R2 dir readback", dir_q, 8'h0F);
    chk("R2 oe inverse", pin_oe, 8'hF0);
    do_write(8'h5A);
    chk("R4 latch with outputs", pin_out, 8'h5A);
  endtask

  task automatic t_pullup();
    pu_off_n = 1'b0; @(negedge clk);
    chk("R5 pullups on inputs only", pin_pu, 8'h0F);
    set_dir(8'hFF);
    chk("R5 pullups all inputs", pin_pu, 8'hFF);
    pu_off_n = 1'b1; @(negedge clk);
    chk("R5 pullups disabled", pin_pu, 8'h00);
  endtask

  task automatic t_read();
    pin_in = 8'h3C; settle();
    do_read();
    chk("R3 read pins", rd_data, 8'h3C);
    clr_chg(); clr_edge();
    chk("R8 clear after read", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_change();
    pin_in = 8'h33; settle();
    chk("R6 low pins ignored flag", {7'b0, chg_flag}, 8'h00);
    chk("R6 low pins ignored wake", {7'b0, wake_req}, 8'h00);
    pin_in = 8'h73; settle();
    chk("R6 upper change flag", {7'b0, chg_flag}, 8'h01);
    chk("R6 upper change wake", {7'b0, wake_req}, 8'h01);
  endtask

  task automatic t_sticky();
    clr_chg();
    chk("R8 clear while mismatch", {7'b0, chg_flag}, 8'h01);
    do_read();
    chk("R9 read ends wake", {7'b0, wake_req}, 8'h00);
    clr_chg();
    chk("R8 clear after read", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_write_ends();
    pin_in = 8'hF3; settle();
    chk("R6 bit7 change", {7'b0, wake_req}, 8'h01);
    do_write(8'h00);
    chk("R9 write ends wake", {7'b0, wake_req}, 8'h00);
    clr_chg(); settle();
    chk("R9 flag stays clear", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_output_excluded();
    set_dir(8'h7F);
    pin_in = 8'h73; settle();
    chk("R7 output pin excluded flag", {7'b0, chg_flag}, 8'h00);
    chk("R7 output pin excluded wake", {7'b0, wake_req}, 8'h00);
    pin_in = 8'hF3; settle();
    set_dir(8'hFF); settle();
    chk("R7 restored no flag", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_edge();
    clr_edge();
    chk("R10 edge cleared", {7'b0, edge_flag}, 8'h00);
    edge_rise = 1'b0;
    pin_in = 8'hF2; settle();
    chk("R10 falling edge", {7'b0, edge_flag}, 8'h01);
    clr_edge();
    pin_in = 8'hF3; settle();
    chk("R10 rise ignored in fall mode", {7'b0, edge_flag}, 8'h00);
    edge_rise = 1'b1;
    pin_in = 8'hF2; settle();
    chk("R10 fall ignored in rise mode", {7'b0, edge_flag}, 8'h00);
    pin_in = 8'hF3; settle();
    chk("R10 rising edge", {7'b0, edge_flag}, 8'h01);
  endtask

  task automatic t_collide();
    clr_edge();
    chk("R11 precondition", {7'b0, edge_flag}, 8'h00);
    edge_rise = 1'b0;
    pin_in = 8'hF2;
    @(posedge clk); @(posedge clk); @(negedge clk);
    edge_clr = 1'b1; @(negedge clk); edge_clr = 1'b0;
    chk("R11 set wins over clear", {7'b0, edge_flag}, 8'h01);
    clr_edge();
    chk("R11 later clear", {7'b0, edge_flag}, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; pin_in = 8'h00; rd_stb = 1'b0; wr_stb = 1'b0; dir_wr = 1'b0;
    wr_data = 8'h00; dir_wdata = 8'hFF; pu_off_n = 1'b1; edge_rise = 1'b1;
    chg_clr = 1'b0; edge_clr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_dir_latch();
    t_pullup();
    t_read();
    t_change();
    t_sticky();
    t_write_ends();
    t_output_excluded();
    t_edge();
    t_collide();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule